// File: doc/BRIEF.md
# Blit Command Stream Generator

This block turns one rectangular copy request into the ordered list of 32-bit command words that a blitter engine runs to move a 32-bit-per-pixel rectangle from a source surface to a destination surface. A request gives the rectangle's width and height, a layout mode for each surface (linear, X-tiled or Y-tiled), a 64-bit base address for each surface, and a flag that selects the newer word format with 64-bit addresses.

A one-cycle start strobe, taken while the block is idle, captures the request. The block then presents the words one at a time on a valid/ready stream. It first writes a tiling-control register so the engine treats each surface as Y-tiled or not. It then emits a flush, the copy command with its operands, and an end-of-batch word. A one-cycle done pulse follows acceptance of the last word. All opcode values, the register address and the flag masks are parameters. The engine that executes the words, and all memory traffic, lie outside the block.

Top module: `blit_cmd_gen`

## Requirements
- R1: After reset, out_valid_o and done_o are low, and they stay low until a start strobe is taken.
- R2: The first three words are the one-register immediate-load opcode (default 32'h2200_0001), the tiling-control register address (default 32'h0002_2200), and a data word. The data word's bits 31:16 hold the mask source-Y|dest-Y (defaults 16'h0001 and 16'h0002, giving 16'h0003). Its bits 15:0 carry source-Y only when the source mode is Y (code 2), and dest-Y only when the destination mode is Y.
- R3: Word 3 is the flush opcode (default 32'h1300_0002), plus one when wide_addr_i is high. Words 4 to 6 are zero.
- R4: Word 7 is the copy opcode (default 32'h54F0_0000) ORed with a length of 6, or 8 when wide_addr_i is high. It also carries the source-tiled mask (32'h0000_8000) when the source mode is X or Y (codes 1, 2), and the dest-tiled mask (32'h0000_0800) when the destination mode is X or Y. Mode code 3 is treated as linear.
- R5: Each surface's pitch is width*4, or plain width when that surface is tiled. The destination pitch sits in bits 15:0 of word 8, ORed with the depth/raster-op constant (default 32'h03CC_0000). The source pitch is the whole source-pitch word.
- R6: After word 8, the words in order are: zero, {height, width} (height in 31:16, width zero-extended in 15:0), destination address low, [destination address high], zero, source pitch, source address low, [source address high].
- R7: The two address-high words appear only when wide_addr_i is high. The stream is then 18 words long, otherwise 16.
- R8: The last word is the end-of-batch opcode (default 32'h0500_0000).
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o hold their values into the next cycle.
- R10: A start strobe while a stream is in progress is ignored. Input changes during a stream do not alter the words that remain.
- R11: done_o is high for exactly the one cycle after the end-of-batch word is accepted, and out_valid_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| width_i | input | 14 | Rectangle width in pixels |
| height_i | input | 16 | Rectangle height in rows |
| src_tile_i | input | 2 | Source layout: 0 linear, 1 X, 2 Y, 3 linear |
| dst_tile_i | input | 2 | Destination layout, same coding |
| src_addr_i | input | 64 | Source base address |
| dst_addr_i | input | 64 | Destination base address |
| wide_addr_i | input | 1 | Newer word format with 64-bit addresses |
| out_valid_o | output | 1 | Command word available |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | 32 | Command word |
| done_o | output | 1 | One-cycle pulse after the final word is accepted |

## Verification
A start taken at one clock edge puts word 0 on the stream right after that edge. Each following word appears right after the edge that accepted the one before it, and done rises right after the edge that accepted the end-of-batch word. The bench drives inputs and reads outputs on the falling edge. At each falling edge it decides ready, compares the word to the expected word for that position, and then checks done at the falling edges after the final accept. It computes every expected word arithmetically from the request, sweeping all layout pairs in both formats, and repeats runs with stalls and mid-stream restarts.

// File: rtl/blit_cmd_pkg.sv
// Package: shared layout-mode type and the fixed slot numbering of the
// command stream. Assumes every stream is at most 18 words.
package blit_cmd_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 64;
    localparam int SLOT_W = 5;

    typedef enum logic [1:0] {
        TILE_LINEAR = 2'd0,
        TILE_X      = 2'd1,
        TILE_Y      = 2'd2,
        TILE_RSVD   = 2'd3
    } tile_mode_e;

    // Slot positions; the high-address slots are skipped in the narrow format.
    localparam logic [SLOT_W-1:0] SL_LRI    = 5'd0;
    localparam logic [SLOT_W-1:0] SL_REG    = 5'd1;
    localparam logic [SLOT_W-1:0] SL_TCTL   = 5'd2;
    localparam logic [SLOT_W-1:0] SL_FLUSH  = 5'd3;
    localparam logic [SLOT_W-1:0] SL_Z0     = 5'd4;
    localparam logic [SLOT_W-1:0] SL_Z1     = 5'd5;
    localparam logic [SLOT_W-1:0] SL_Z2     = 5'd6;
    localparam logic [SLOT_W-1:0] SL_COPY   = 5'd7;
    localparam logic [SLOT_W-1:0] SL_DPITCH = 5'd8;
    localparam logic [SLOT_W-1:0] SL_DORG   = 5'd9;
    localparam logic [SLOT_W-1:0] SL_DIMS   = 5'd10;
    localparam logic [SLOT_W-1:0] SL_DLO    = 5'd11;
    localparam logic [SLOT_W-1:0] SL_DHI    = 5'd12;
    localparam logic [SLOT_W-1:0] SL_SORG   = 5'd13;
    localparam logic [SLOT_W-1:0] SL_SPITCH = 5'd14;
    localparam logic [SLOT_W-1:0] SL_SLO    = 5'd15;
    localparam logic [SLOT_W-1:0] SL_SHI    = 5'd16;
    localparam logic [SLOT_W-1:0] SL_END    = 5'd17;

    typedef struct packed {
        tile_mode_e         src_tile;
        tile_mode_e         dst_tile;
        logic               wide;
        logic [13:0]        width;
        logic [15:0]        height;
        logic [ADDR_W-1:0]  src_addr;
        logic [ADDR_W-1:0]  dst_addr;
    } blit_req_t;
endpackage

// File: rtl/blit_seq.sv
// Sequencer: walks the slot counter one step per accepted word, skipping
// the high-address slots in the narrow format, and pulses done after the
// last slot is accepted. Assumes wide_i is stable while busy.
module blit_seq
    import blit_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic              ready_i,
    output logic              busy_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              done_o
);
    logic              fire;
    logic              last;
    logic [SLOT_W-1:0] nxt;

    assign fire = busy_o && ready_i;
    assign last = (slot_o == SL_END);

    // Next slot: step by one, or by two over an omitted high-address word.
    always_comb begin
        nxt = slot_o + 5'd1;
        if (!wide_i && (nxt == SL_DHI || nxt == SL_SHI))
            nxt = slot_o + 5'd2;
    end

    // Busy flag, slot counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            slot_o <= SL_LRI;
            done_o <= 1'b0;
        end else begin
            done_o <= fire && last;
            if (!busy_o) begin
                if (start_i) begin
                    busy_o <= 1'b1;
                    slot_o <= SL_LRI;
                end
            end else if (fire) begin
                if (last) busy_o <= 1'b0;
                else      slot_o <= nxt;
            end
        end
    end

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !ready_i |=> busy_o && $stable(slot_o));
    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !ready_i |=> $stable(slot_o));
    p_skip_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !wide_i |-> slot_o != SL_DHI && slot_o != SL_SHI);
    p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire && last |=> done_o && !busy_o);
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/blit_word_fmt.sv
// Word formatter: pure combinational map from slot number and the captured
// request to the command word for that slot. Assumes width*4 fits 16 bits.
module blit_word_fmt
    import blit_cmd_pkg::*;
#(
    parameter logic [31:0] LRI_WORD     = 32'h2200_0001,
    parameter logic [31:0] TCTL_ADDR    = 32'h0002_2200,
    parameter logic [15:0] SRC_Y_MASK   = 16'h0001,
    parameter logic [15:0] DST_Y_MASK   = 16'h0002,
    parameter logic [31:0] FLUSH_OP     = 32'h1300_0002,
    parameter logic [31:0] COPY_OP      = 32'h54F0_0000,
    parameter logic [31:0] SRC_TILED    = 32'h0000_8000,
    parameter logic [31:0] DST_TILED    = 32'h0000_0800,
    parameter logic [31:0] DEPTH_ROP    = 32'h03CC_0000,
    parameter logic [31:0] END_WORD     = 32'h0500_0000,
    parameter int          LEN_NARROW   = 6,
    parameter int          LEN_WIDE     = 8
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  blit_req_t         req_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [15:0] Y_WMASK = SRC_Y_MASK | DST_Y_MASK;

    logic        src_tiled, dst_tiled;
    logic [15:0] src_pitch, dst_pitch, y_bits;
    logic [31:0] copy_word;

    // Derived fields shared by several slots.
    always_comb begin
        src_tiled = (req_i.src_tile == TILE_X) || (req_i.src_tile == TILE_Y);
        dst_tiled = (req_i.dst_tile == TILE_X) || (req_i.dst_tile == TILE_Y);
        src_pitch = src_tiled ? {2'b00, req_i.width} : {req_i.width, 2'b00};
        dst_pitch = dst_tiled ? {2'b00, req_i.width} : {req_i.width, 2'b00};
        y_bits    = ((req_i.src_tile == TILE_Y) ? SRC_Y_MASK : 16'h0)
                  | ((req_i.dst_tile == TILE_Y) ? DST_Y_MASK : 16'h0);
        copy_word = COPY_OP
                  | (req_i.wide ? 32'(LEN_WIDE) : 32'(LEN_NARROW))
                  | (src_tiled ? SRC_TILED : 32'h0)
                  | (dst_tiled ? DST_TILED : 32'h0);
    end

    // Slot-to-word selection.
    always_comb begin
        unique case (slot_i)
            SL_LRI:    word_o = LRI_WORD;
            SL_REG:    word_o = TCTL_ADDR;
            SL_TCTL:   word_o = {Y_WMASK, y_bits};
            SL_FLUSH:  word_o = FLUSH_OP + {31'h0, req_i.wide};
            SL_COPY:   word_o = copy_word;
            SL_DPITCH: word_o = DEPTH_ROP | {16'h0, dst_pitch};
            SL_DIMS:   word_o = {req_i.height, 2'b00, req_i.width};
            SL_DLO:    word_o = req_i.dst_addr[31:0];
            SL_DHI:    word_o = req_i.dst_addr[63:32];
            SL_SPITCH: word_o = {16'h0, src_pitch};
            SL_SLO:    word_o = req_i.src_addr[31:0];
            SL_SHI:    word_o = req_i.src_addr[63:32];
            SL_END:    word_o = END_WORD;
            default:   word_o = '0;
        endcase
    end
endmodule

// File: rtl/blit_cmd_gen.sv
// Top: captures a copy request on an idle start strobe and streams its
// command words on a valid/ready interface, then pulses done.
// Assumes the consumer may stall at any time.
module blit_cmd_gen
    import blit_cmd_pkg::*;
#(
    parameter logic [31:0] LRI_WORD   = 32'h2200_0001,
    parameter logic [31:0] TCTL_ADDR  = 32'h0002_2200,
    parameter logic [15:0] SRC_Y_MASK = 16'h0001,
    parameter logic [15:0] DST_Y_MASK = 16'h0002,
    parameter logic [31:0] FLUSH_OP   = 32'h1300_0002,
    parameter logic [31:0] COPY_OP    = 32'h54F0_0000,
    parameter logic [31:0] SRC_TILED  = 32'h0000_8000,
    parameter logic [31:0] DST_TILED  = 32'h0000_0800,
    parameter logic [31:0] DEPTH_ROP  = 32'h03CC_0000,
    parameter logic [31:0] END_WORD   = 32'h0500_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [13:0] width_i,
    input  logic [15:0] height_i,
    input  logic [1:0]  src_tile_i,
    input  logic [1:0]  dst_tile_i,
    input  logic [63:0] src_addr_i,
    input  logic [63:0] dst_addr_i,
    input  logic        wide_addr_i,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [31:0] out_data_o,
    output logic        done_o
);
    blit_req_t         req_q;
    logic              busy;
    logic [SLOT_W-1:0] slot;

    // Request capture, only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (start_i && !busy) begin
            req_q.src_tile <= tile_mode_e'(src_tile_i);
            req_q.dst_tile <= tile_mode_e'(dst_tile_i);
            req_q.wide     <= wide_addr_i;
            req_q.width    <= width_i;
            req_q.height   <= height_i;
            req_q.src_addr <= src_addr_i;
            req_q.dst_addr <= dst_addr_i;
        end
    end

    blit_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .wide_i  (req_q.wide),
        .ready_i (out_ready_i),
        .busy_o  (busy),
        .slot_o  (slot),
        .done_o  (done_o)
    );

    blit_word_fmt #(
        .LRI_WORD   (LRI_WORD),
        .TCTL_ADDR  (TCTL_ADDR),
        .SRC_Y_MASK (SRC_Y_MASK),
        .DST_Y_MASK (DST_Y_MASK),
        .FLUSH_OP   (FLUSH_OP),
        .COPY_OP    (COPY_OP),
        .SRC_TILED  (SRC_TILED),
        .DST_TILED  (DST_TILED),
        .DEPTH_ROP  (DEPTH_ROP),
        .END_WORD   (END_WORD)
    ) u_fmt (
        .slot_i (slot),
        .req_i  (req_q),
        .word_o (out_data_o)
    );

    assign out_valid_o = busy;

    p_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> $stable(req_q) || !$past(out_valid_o));
    p_end_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(out_data_o) == END_WORD);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !out_valid_o);
endmodule

// File: tb/blit_cmd_gen_tb.sv
// Bench: sweeps every layout pair in both formats, then stalled runs with
// restart attempts; expected words are computed here from the requirements.
module blit_cmd_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [13:0] width_i = '0;
    logic [15:0] height_i = '0;
    logic [1:0]  src_tile_i = '0, dst_tile_i = '0;
    logic [63:0] src_addr_i = '0, dst_addr_i = '0;
    logic        wide_addr_i = 1'b0;
    logic        out_valid_o, out_ready_i = 1'b1, done_o;
    logic [31:0] out_data_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] exp_w [0:17];
    string       exp_t [0:17];
    int          exp_n;

    always #5 clk = ~clk;

    blit_cmd_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .width_i(width_i),
        .height_i(height_i), .src_tile_i(src_tile_i), .dst_tile_i(dst_tile_i),
        .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
        .wide_addr_i(wide_addr_i), .out_valid_o(out_valid_o),
        .out_ready_i(out_ready_i), .out_data_o(out_data_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w, input string tag);
        exp_w[exp_n] = w;
        exp_t[exp_n] = tag;
        exp_n++;
    endtask

    // Build the expected stream from the requirement text.
    task automatic build(input int st, input int dt, input bit g, input int w,
                         input int h, input logic [63:0] sa, input logic [63:0] da);
        logic [15:0] yb, sp, dp;
        logic [31:0] cp;
        exp_n = 0;
        yb = ((st == 2) ? 16'h1 : 16'h0) | ((dt == 2) ? 16'h2 : 16'h0);
        sp = (st == 1 || st == 2) ? 16'(w) : 16'(w * 4);
        dp = (dt == 1 || dt == 2) ? 16'(w) : 16'(w * 4);
        cp = 32'h54F0_0000 | (g ? 32'd8 : 32'd6)
           | ((st == 1 || st == 2) ? 32'h8000 : 32'h0)
           | ((dt == 1 || dt == 2) ? 32'h0800 : 32'h0);
        push(32'h2200_0001, "R2"); push(32'h0002_2200, "R2");
        push({16'h0003, yb}, "R2");
        push(32'h1300_0002 + (g ? 32'd1 : 32'd0), "R3");
        push(0, "R3"); push(0, "R3"); push(0, "R3");
        push(cp, "R4");
        push(32'h03CC_0000 | {16'h0, dp}, "R5");
        push(0, "R6"); push({16'(h), 16'(w)}, "R6");
        push(da[31:0], "R6");
        if (g) push(da[63:32], "R7");
        push(0, "R6"); push({16'h0, sp}, "R5");
        push(sa[31:0], "R6");
        if (g) push(sa[63:32], "R7");
        push(32'h0500_0000, "R8");
    endtask

    task automatic run_case(input int st, input int dt, input bit g, input int w,
                            input int h, input logic [63:0] sa,
                            input logic [63:0] da, input bit stall);
        int idx = 0;
        int cyc = 0;
        bit hold = 0;
        logic [31:0] hdata = '0;
        build(st, dt, g, w, h, sa, da);
        check(exp_n == (g ? 18 : 16), "R7", 32'(exp_n), g ? 32'd18 : 32'd16);
        @(negedge clk);
        src_tile_i = 2'(st); dst_tile_i = 2'(dt); wide_addr_i = g;
        width_i = 14'(w); height_i = 16'(h); src_addr_i = sa; dst_addr_i = da;
        out_ready_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (stall) begin
            // R10: new inputs during the stream must not matter.
            src_tile_i = 2'(2 - st % 3); dst_tile_i = 2'(3 - dt);
            wide_addr_i = ~g; width_i = ~width_i; height_i = ~height_i;
            src_addr_i = ~sa; dst_addr_i = ~da;
        end
        while (idx < exp_n) begin
            if (hold) check(out_valid_o && out_data_o == hdata, "R9", out_data_o, hdata);
            if (!out_valid_o) begin
                check(0, exp_t[idx], 32'(out_valid_o), 32'd1);
                break;
            end
            check(!done_o, "R11", 32'(done_o), 32'd0);
            out_ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
            start_i = stall && (cyc == 4 || cyc == 7);
            if (out_ready_i) begin
                check(out_data_o == exp_w[idx],
                      stall ? {exp_t[idx], " R10"} : exp_t[idx],
                      out_data_o, exp_w[idx]);
                idx++;
                hold = 0;
            end else begin
                hold = 1;
                hdata = out_data_o;
            end
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0; out_ready_i = 1'b1;
        check(done_o && !out_valid_o, "R11", {30'h0, done_o, out_valid_o}, 32'h2);
        @(negedge clk);
        check(!done_o && !out_valid_o, "R11", {30'h0, done_o, out_valid_o}, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid_o && !done_o, "R1", {30'h0, out_valid_o, done_o}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid_o && !done_o, "R1", {30'h0, out_valid_o, done_o}, 32'h0);
        for (int st = 0; st < 3; st++)
            for (int dt = 0; dt < 3; dt++)
                for (int g = 0; g < 2; g++)
                    run_case(st, dt, g[0], 16 + st * 5 + dt, 8 + g * 3,
                             64'h0000_00A1_0040_0000 + 64'(st << 12),
                             64'h0000_01B2_0080_1000 + 64'(dt << 16), 1'b0);
        run_case(3, 3, 1'b1, 16383, 65535, 64'hFFEE_DDCC_BBAA_9988,
                 64'h1234_5678_9ABC_DEF0, 1'b1);
        run_case(2, 1, 1'b0, 1, 1, 64'h0000_0000_0000_1000,
                 64'h8000_0000_0000_2000, 1'b1);
        run_case(1, 2, 1'b1, 512, 32, 64'h0000_0003_0001_0000,
                 64'h0000_0004_0002_0000, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule